// File: doc/BRIEF.md
# Mode-Switched Seven-Segment Display Controller

This block drives five active-low seven-segment digit outputs from a two-bit mode selector, a four-bit BCD value and a one-bit speed select. Each mode owns a fixed set of digits. The decode mode shows the BCD value on digit 4. The counting mode steps an 8-bit up-counter once per period and shows it as two hex digits on digits 0 and 1. The pattern mode steps an 8-bit pseudo-random byte once per period and shows it on digits 2 and 3.

Every digit keeps its last value while its mode is not selected, so switching modes freezes what was on screen. Entering counting mode clears the counter. Entering pattern mode continues from the frozen byte. One shared step timer sets the pace. Its period is derived from the `CLK_HZ` parameter and selected by the speed input. The timer starts a fresh period whenever the mode or the speed input changes.

Top module: `seg_mode_ctrl`

## Requirements
- R1: After reset, digits 0 and 1 show 0 and 0, digit 2 shows 1, digit 3 shows 0, and digit 4 is blank (0xFF).
- R2: Segment bytes are active-low, with bit 0 = a through bit 6 = g and bit 7 = decimal point, which is always 1. With mode 01, one clock after the BCD input is sampled, digit 4 shows 0..9 as C0, F9, A4, B0, 99, 92, 82, F8, 80, 90.
- R3: With mode 01, a BCD input of 10..15 shows a blank digit 4 (0xFF).
- R4: Mode 10 runs an 8-bit counter: digit 0 shows the low nibble and digit 1 the high nibble. Hex A..F are shown as 88, 83, C6, A1, 86, 8E. The counter increments by one per step.
- R5: The counter wraps from 0xFF to 0x00.
- R6: Outside mode 10 the counter value is held. On entering mode 10 it restarts at 0x00 on the first clock.
- R7: Mode 11 steps a byte through next = {v[6:0], v[7]^v[5]^v[4]^v[3]}, starting from 0x01 after reset. Digit 2 shows the low nibble and digit 3 the high nibble. The byte is held outside mode 11 and continues from the held value on re-entry.
- R8: A step occurs every CLK_HZ*3/10 clocks when the speed input is 1, and every CLK_HZ/8 clocks when it is 0.
- R9: A change of the mode or speed input starts a new full period. The first step after such a change comes one full period after the clock that sampled it.
- R10: Mode 00 changes no digit, and digit 4 keeps its last decoded value in every mode other than 01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 idle, 01 BCD decode, 10 counter, 11 pattern |
| bcd | input | 4 | BCD value for digit 4 |
| slow | input | 1 | 1 selects the long step period, 0 the short one |
| seg0 | output | 8 | Counter low hex digit |
| seg1 | output | 8 | Counter high hex digit |
| seg2 | output | 8 | Pattern low hex digit |
| seg3 | output | 8 | Pattern high hex digit |
| seg4 | output | 8 | Decoded BCD digit |

## Verification
The hardest state to reach is the counter wrap, because it needs 256 paced steps. The bench shrinks `CLK_HZ` so that a period is only 25 or 60 clocks, and then runs the whole count. A speed change in the middle of a period is just as hard to observe. The bench switches speed partway through a short period and checks two things: no step appears at the old deadline, and the next step lands exactly one long period later.

// File: rtl/segdisp_pkg.sv
package segdisp_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'b00,
        MODE_BCD  = 2'b01,
        MODE_CNT  = 2'b10,
        MODE_PAT  = 2'b11
    } mode_e;

    localparam int NIB_W  = 4;
    localparam int DATA_W = 8;
    localparam int DIGITS = DATA_W / NIB_W;

    // Active-low segment byte: dp is bit 7, segments g..a are bits 6..0.
    typedef struct packed {
        logic       dp;
        logic [6:0] gfedcba;
    } seg_t;

    localparam seg_t SEG_BLANK = '{dp: 1'b1, gfedcba: 7'h7F};

    function automatic seg_t nib_to_seg(input logic [NIB_W-1:0] n);
        logic [6:0] lit;
        case (n)
            4'h0: lit = 7'h3F;
            4'h1: lit = 7'h06;
            4'h2: lit = 7'h5B;
            4'h3: lit = 7'h4F;
            4'h4: lit = 7'h66;
            4'h5: lit = 7'h6D;
            4'h6: lit = 7'h7D;
            4'h7: lit = 7'h07;
            4'h8: lit = 7'h7F;
            4'h9: lit = 7'h6F;
            4'hA: lit = 7'h77;
            4'hB: lit = 7'h7C;
            4'hC: lit = 7'h39;
            4'hD: lit = 7'h5E;
            4'hE: lit = 7'h79;
            default: lit = 7'h71;
        endcase
        return '{dp: 1'b1, gfedcba: ~lit};
    endfunction

    function automatic seg_t bcd_to_seg(input logic [NIB_W-1:0] n);
        return (n > 4'd9) ? SEG_BLANK : nib_to_seg(n);
    endfunction

endpackage

// File: rtl/step_timer.sv
module step_timer #(
    parameter int SLOW_CYC = 15_000_000,
    parameter int FAST_CYC = 6_250_000
) (
    input  logic clk,
    input  logic rst,
    input  logic slow,
    input  logic restart,
    output logic tick
);
    localparam int MAX_CYC = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC);
    localparam logic [CNT_W-1:0] SLOW_LD = CNT_W'(SLOW_CYC - 1);
    localparam logic [CNT_W-1:0] FAST_LD = CNT_W'(FAST_CYC - 1);

    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] load_val;
    logic             slow_q;
    logic             reload_now;

    assign load_val   = slow ? SLOW_LD : FAST_LD;
    assign reload_now = restart || (slow != slow_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= load_val;
            slow_q <= slow;
        end else begin
            slow_q <= slow;
            if (reload_now || remain == '0) begin
                remain <= load_val;
            end else begin
                remain <= remain - 1'b1;
            end
        end
    end

    assign tick = (remain == '0) && !reload_now;

endmodule

// File: rtl/step_counter.sv
module step_counter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             enter,
    input  logic             step,
    output logic [WIDTH-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (active) begin
            if (enter) begin
                value <= '0;
            end else if (step) begin
                value <= value + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lfsr_pattern.sv
module lfsr_pattern #(
    parameter int               WIDTH = 8,
    parameter logic [WIDTH-1:0] TAPS  = 8'hB8,
    parameter logic [WIDTH-1:0] SEED  = 8'h01
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             step,
    output logic [WIDTH-1:0] value
);
    logic feedback;

    assign feedback = ^(value & TAPS);

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= SEED;
        end else if (active && step) begin
            value <= {value[WIDTH-2:0], feedback};
        end
    end
endmodule

// File: rtl/seg_mode_ctrl.sv
module seg_mode_ctrl
    import segdisp_pkg::*;
#(
    parameter int          CLK_HZ    = 50_000_000,
    parameter logic [7:0]  LFSR_TAPS = 8'hB8,
    parameter logic [7:0]  LFSR_SEED = 8'h01
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic [3:0] bcd,
    input  logic       slow,
    output logic [7:0] seg0,
    output logic [7:0] seg1,
    output logic [7:0] seg2,
    output logic [7:0] seg3,
    output logic [7:0] seg4
);
    localparam int SLOW_CYC = CLK_HZ * 3 / 10;
    localparam int FAST_CYC = CLK_HZ / 8;

    mode_e             mode_cur;
    mode_e             mode_q;
    logic              mode_change;
    logic              tick;
    logic [NIB_W-1:0]  bcd_hold;
    logic [DATA_W-1:0] cnt_val;
    logic [DATA_W-1:0] pat;
    seg_t              cnt_seg [DIGITS];
    seg_t              pat_seg [DIGITS];

    assign mode_cur    = mode_e'(mode);
    assign mode_change = (mode_cur != mode_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_IDLE;
            bcd_hold <= 4'hF;
        end else begin
            mode_q <= mode_cur;
            if (mode_cur == MODE_BCD) begin
                bcd_hold <= bcd;
            end
        end
    end

    step_timer #(
        .SLOW_CYC (SLOW_CYC),
        .FAST_CYC (FAST_CYC)
    ) i_timer (
        .clk     (clk),
        .rst     (rst),
        .slow    (slow),
        .restart (mode_change),
        .tick    (tick)
    );

    step_counter #(
        .WIDTH (DATA_W)
    ) i_counter (
        .clk    (clk),
        .rst    (rst),
        .active (mode_cur == MODE_CNT),
        .enter  (mode_change),
        .step   (tick),
        .value  (cnt_val)
    );

    lfsr_pattern #(
        .WIDTH (DATA_W),
        .TAPS  (LFSR_TAPS),
        .SEED  (LFSR_SEED)
    ) i_pattern (
        .clk    (clk),
        .rst    (rst),
        .active (mode_cur == MODE_PAT),
        .step   (tick),
        .value  (pat)
    );

    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        assign cnt_seg[d] = nib_to_seg(cnt_val[d*NIB_W +: NIB_W]);
        assign pat_seg[d] = nib_to_seg(pat[d*NIB_W +: NIB_W]);
    end

    assign seg0 = cnt_seg[0];
    assign seg1 = cnt_seg[1];
    assign seg2 = pat_seg[0];
    assign seg3 = pat_seg[1];
    assign seg4 = bcd_to_seg(bcd_hold);

endmodule

// File: rtl/seg_mode_chk.sv
module seg_mode_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode,
    input logic [1:0] mode_q,
    input logic [3:0] bcd,
    input logic       tick,
    input logic [7:0] cnt_val,
    input logic [7:0] pat,
    input logic [7:0] seg0,
    input logic [7:0] seg1,
    input logic [7:0] seg2,
    input logic [7:0] seg3,
    input logic [7:0] seg4
);
    AST_DP_DARK: assert property (@(posedge clk) disable iff (rst)
        (seg0[7] && seg1[7] && seg2[7] && seg3[7] && seg4[7])); // R2

    AST_BCD_BLANK: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && bcd > 4'd9) |=> (seg4 == 8'hFF)); // R3

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10 && mode_q == 2'b10 && tick) |=> (cnt_val == 8'($past(cnt_val) + 8'd1))); // R4

    AST_CNT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10 && mode_q != 2'b10) |=> (cnt_val == 8'h00)); // R6

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'b10) |=> $stable(cnt_val)); // R6

    AST_PAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'b11) |=> $stable(pat)); // R7

    AST_PAT_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (pat != 8'h00)); // R7

    AST_TICK_PULSE: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R8

    AST_BCD_KEEP: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'b01) |=> $stable(seg4)); // R10
endmodule

bind seg_mode_ctrl seg_mode_chk i_chk (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .mode_q  (mode_q),
    .bcd     (bcd),
    .tick    (tick),
    .cnt_val (cnt_val),
    .pat     (pat),
    .seg0    (seg0),
    .seg1    (seg1),
    .seg2    (seg2),
    .seg3    (seg3),
    .seg4    (seg4)
);

// File: tb/test_seg_mode_ctrl.sv
`timescale 1ns/1ps
module test_seg_mode_ctrl;
    localparam int HZ = 200;
    localparam int PF = HZ / 8;
    localparam int PS = HZ * 3 / 10;

    // {bcd, expected digit 4}
    localparam logic [11:0] BCD_VEC [16] = '{
        12'h0C0, 12'h1F9, 12'h2A4, 12'h3B0, 12'h499, 12'h592, 12'h682, 12'h7F8,
        12'h880, 12'h990, 12'hAFF, 12'hBFF, 12'hCFF, 12'hDFF, 12'hEFF, 12'hFFF
    };

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] mode;
    logic [3:0] bcd;
    logic       slow;
    logic [7:0] seg0, seg1, seg2, seg3, seg4;
    int         total = 0;
    int         bad = 0;
    logic [7:0] p;

    always #2.5 clk = ~clk;

    seg_mode_ctrl #(.CLK_HZ(HZ)) i_seg_mode_ctrl (
        .clk(clk), .rst(rst), .mode(mode), .bcd(bcd), .slow(slow),
        .seg0(seg0), .seg1(seg1), .seg2(seg2), .seg3(seg3), .seg4(seg4)
    );

    function automatic logic [7:0] hex_code(input logic [3:0] n);
        case (n)
            4'h0: return 8'hC0;  4'h1: return 8'hF9;  4'h2: return 8'hA4;  4'h3: return 8'hB0;
            4'h4: return 8'h99;  4'h5: return 8'h92;  4'h6: return 8'h82;  4'h7: return 8'hF8;
            4'h8: return 8'h80;  4'h9: return 8'h90;  4'hA: return 8'h88;  4'hB: return 8'h83;
            4'hC: return 8'hC6;  4'hD: return 8'hA1;  4'hE: return 8'h86;  default: return 8'h8E;
        endcase
    endfunction

    function automatic logic [7:0] next_pat(input logic [7:0] v);
        return {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_cnt(input string tag, input logic [7:0] v);
        check(tag, seg0, hex_code(v[3:0]));
        check(tag, seg1, hex_code(v[7:4]));
    endtask

    task automatic check_pat(input string tag, input logic [7:0] v);
        check(tag, seg2, hex_code(v[3:0]));
        check(tag, seg3, hex_code(v[7:4]));
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; mode = 2'b00; bcd = 4'h0; slow = 1'b0;
        wait_n(3);
        rst = 1'b0;
        // R1 reset state
        check("R1 seg0", seg0, 8'hC0);
        check("R1 seg1", seg1, 8'hC0);
        check("R1 seg2", seg2, 8'hF9);
        check("R1 seg3", seg3, 8'hC0);
        check("R1 seg4", seg4, 8'hFF);

        // R2/R3 decode table walk
        mode = 2'b01;
        for (int i = 0; i < 16; i++) begin
            bcd = BCD_VEC[i][11:8];
            wait_n(1);
            check((i < 10) ? "R2 decode" : "R3 blank", seg4, BCD_VEC[i][7:0]);
        end

        // R10 idle mode and hold of digit 4
        bcd = 4'h3;
        wait_n(1);
        mode = 2'b00; bcd = 4'h7;
        wait_n(5 * PF);
        check("R10 digit4 hold", seg4, 8'hB0);
        check_cnt("R10 counter idle", 8'h00);
        check_pat("R10 pattern idle", 8'h01);

        // R4 counter steps, R5 wrap
        mode = 2'b10;
        wait_n(PF);
        check_cnt("R4 before first step", 8'h00);
        wait_n(1);
        check_cnt("R4 first step", 8'h01);
        wait_n(PF * 170);
        check_cnt("R4 hex letters", 8'hAB);
        wait_n(PF * 84);
        check_cnt("R5 top", 8'hFF);
        wait_n(PF);
        check_cnt("R5 wrap", 8'h00);
        wait_n(PF * 5);
        check_cnt("R4 after wrap", 8'h05);

        // R6 freeze and restart
        mode = 2'b00;
        wait_n(PF * 3);
        check_cnt("R6 frozen", 8'h05);
        bcd = 4'h9;
        check("R10 digit4 in idle", seg4, 8'hB0);
        mode = 2'b10;
        wait_n(1);
        check_cnt("R6 restart", 8'h00);
        wait_n(PF - 1);
        check_cnt("R9 full period after entry", 8'h00);
        wait_n(1);
        check_cnt("R9 step after entry", 8'h01);

        // R9 speed change mid-period, R8 slow period
        wait_n(10);
        slow = 1'b1;
        wait_n(PS);
        check_cnt("R9 no step at old deadline", 8'h01);
        wait_n(1);
        check_cnt("R8 slow step", 8'h02);
        wait_n(PS);
        check_cnt("R8 slow period", 8'h03);

        // R7 pattern
        p = 8'h01;
        slow = 1'b0; mode = 2'b11;
        wait_n(PF);
        check_pat("R7 before first step", p);
        wait_n(1);
        p = next_pat(p);
        check_pat("R7 step", p);
        for (int k = 0; k < 6; k++) begin
            wait_n(PF);
            p = next_pat(p);
            check_pat("R7 sequence", p);
        end
        check_cnt("R6 counter held in pattern mode", 8'h03);
        check("R10 digit4 in pattern mode", seg4, 8'hB0);

        mode = 2'b01;
        wait_n(PF * 3);
        check_pat("R7 frozen", p);
        check("R2 decode 9", seg4, 8'h90);
        mode = 2'b11;
        wait_n(PF);
        check_pat("R7 resume hold", p);
        wait_n(1);
        p = next_pat(p);
        check_pat("R7 resume step", p);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule